// File: doc/BRIEF.md
# Battery-Backed Key Store Controller

The block is a 32-bit register-mapped controller for a nine-word secret key store, reached through a simple APB-style slave port with no wait states. Software first unlocks programming with a fixed magic value. The unlock wipes the store, and only after it do writes to the key words take effect. Key words never read back, and a self-clearing command can wipe the store at any time. A checksum register lets software confirm the loaded key. The block compares the written value against a CRC-32C that it computes itself, one word per clock, over the first eight key words.

The ninth word has two build-time options. It can be write-only: it then reads as zero, it is wiped with the rest of the store, and it can never be locked. Or it can be readable: it then survives a wipe and can be frozen by a sticky lock bit. A status/mask/enable/disable register group drives one interrupt line from an external event input.

Two resets are provided. The functional reset `rst_n` restores every control register but leaves the key words alone. The power-on reset `por_n` also clears the key words.

Top module: `keystore_ctrl`

## Requirements
- R1: A write takes effect only when `psel`, `penable` and `pwrite` are all high and `paddr[1:0]` is 00. A read with `paddr[1:0]` not 00, or a read of an offset with no register, returns zero. `prdata` is zero when no read is in progress.
- R2: Writing exactly 0x757BDF0D to offset 0x08 wipes the store and sets status (offset 0x00) bit 0, the programming flag. Any other value written there does nothing. The flag stays set until a reset, and offset 0x08 reads as zero.
- R3: Writes to key words 0 to 7 (offsets 0x10 to 0x2C) are dropped while the programming flag is clear. Those offsets and the checksum register at 0x0C always read as zero.
- R4: Writing 1 to bit 0 of offset 0x04 wipes key words 0 to 7 and sets status bit 4, the wiped flag. Offset 0x04 always reads as zero.
- R5: An accepted key-word write with a non-zero value clears status bit 4. The one exception is a write to word 8 (offset 0x30) when word 8 is readable.
- R6: A write to 0x0C while the programming flag is clear changes nothing. While the flag is set, the write clears status bits 8 (done) and 9 (pass) and starts the checksum. Bit 8 rises only when the checksum has finished.
- R7: The checksum is a reflected CRC-32C: polynomial 0x82F63B78, start value 0xFFFFFFFF, result inverted. Each 32-bit word is fed least significant bit first, in the order word 7 down to word 0. When word 8 is write-only, an all-zero word is fed before word 7. Bit 9 is set when the result equals the written value.
- R8: With `WORD8_WO`=1, offset 0x30 reads as zero, word 8 is wiped along with the other words, and the lock bit (offset 0x4C bit 0) stays 0.
- R9: With `WORD8_WO`=0, offset 0x30 reads back the stored word. The word survives a wipe, and it can be written only while the programming flag is set and the lock bit is clear.
- R10: Lock bit 0 at 0x4C is sticky. A written 1 sets it, a written 0 leaves it unchanged, and only a reset clears it.
- R11: Interrupt status 0x38 bit 0 is set by `irq_evt` and cleared by writing a 1; a new event in the same cycle wins. Mask 0x3C resets to 1 and ignores direct writes. A 1 written to 0x40 clears the mask bit and a 1 written to 0x44 sets it; both of those offsets read as zero. `irq` is high when the status bit is 1 and the mask bit is 0.
- R12: `rst_n` returns status to 0, mask to 1, and lock, slave-error enable and interrupt status to 0, and it leaves the key words unchanged. `por_n` also clears the key words.
- R13: Slave-error enable at 0x34 bit 0 is a plain read/write bit that resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything including keys |
| rst_n | input | 1 | Functional reset, active low, keeps key words |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 7 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational |
| irq_evt | input | 1 | Interrupt source event, sets status bit 0 |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds two copies of the block side by side on one shared bus, one with `WORD8_WO`=1 and one with `WORD8_WO`=0. Every access therefore shows both policies for the ninth word at once. One write reaches both copies, and the two read values are compared against separate expected results.

This pairing exposes the exception to the wiped-flag rule, the lock being ignored in the write-only build, and word 8 surviving a wipe and a functional reset. It also shows that the leading zero word changes the checksum: a single written value passes in one copy and fails in the other.

// File: rtl/keystore_pkg.sv
package keystore_pkg;
    localparam int DATA_W  = 32;
    localparam int REG_AW  = 7;
    localparam int NUM_KEY = 9;

    localparam logic [REG_AW-1:0] OFS_STAT  = 7'h00;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 7'h04;
    localparam logic [REG_AW-1:0] OFS_UNLK  = 7'h08;
    localparam logic [REG_AW-1:0] OFS_CSUM  = 7'h0C;
    localparam logic [REG_AW-1:0] OFS_KEY0  = 7'h10;
    localparam logic [REG_AW-1:0] OFS_SERR  = 7'h34;
    localparam logic [REG_AW-1:0] OFS_ISTAT = 7'h38;
    localparam logic [REG_AW-1:0] OFS_IMASK = 7'h3C;
    localparam logic [REG_AW-1:0] OFS_IEN   = 7'h40;
    localparam logic [REG_AW-1:0] OFS_IDIS  = 7'h44;
    localparam logic [REG_AW-1:0] OFS_LOCK  = 7'h4C;

    localparam int ST_PGM  = 0;
    localparam int ST_WIPE = 4;
    localparam int ST_DONE = 8;
    localparam int ST_PASS = 9;

    localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'h757B_DF0D;
    localparam logic [DATA_W-1:0] CRC_POLY    = 32'h82F6_3B78;

    typedef struct packed {
        logic              pgm;
        logic              wiped;
        logic              done;
        logic              pass;
        logic              lock;
        logic              serr_en;
        logic [DATA_W-1:0] csum;
    } ctl_st_t;

    // One word into a reflected CRC, LSB first.
    function automatic logic [DATA_W-1:0] crc_word(input logic [DATA_W-1:0] crc,
                                                   input logic [DATA_W-1:0] din);
        logic [DATA_W-1:0] c;
        c = crc ^ din;
        for (int b = 0; b < DATA_W; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/keystore_bank.sv
module keystore_bank #(
    parameter int NUM_W = 9,
    parameter int DW    = 32
) (
    input  logic                      clk,
    input  logic                      por_n,
    input  logic [NUM_W-1:0]          we,
    input  logic [NUM_W-1:0]          clr,
    input  logic [DW-1:0]             wdata,
    output logic [NUM_W-1:0][DW-1:0]  words
);
    logic [NUM_W-1:0][DW-1:0] words_d, words_q;

    for (genvar i = 0; i < NUM_W; i++) begin : g_word
        always_comb begin
            if (clr[i]) begin
                words_d[i] = '0;
            end else if (we[i]) begin
                words_d[i] = wdata;
            end else begin
                words_d[i] = words_q[i];
            end
        end
    end

    // Only power-on reset touches the key contents.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            words_q <= '0;
        end else begin
            words_q <= words_d;
        end
    end

    assign words = words_q;
endmodule

// File: rtl/keystore_crc.sv
module keystore_crc
    import keystore_pkg::*;
#(
    parameter int NUM_SUM   = 8,
    parameter bit LEAD_ZERO = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [NUM_SUM-1:0][DATA_W-1:0] words,
    output logic                           fin,
    output logic [DATA_W-1:0]              result
);
    localparam int IW        = $clog2(NUM_SUM + 1);
    localparam int FEED_N    = 2 ** IW;
    localparam int START_IDX = LEAD_ZERO ? NUM_SUM : NUM_SUM - 1;

    typedef struct packed {
        logic              busy;
        logic              fin;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] crc;
    } crc_st_t;

    crc_st_t st_d, st_q;
    logic [FEED_N-1:0][DATA_W-1:0] feed;
    logic [DATA_W-1:0] din;

    always_comb begin
        feed = '0;
        for (int k = 0; k < NUM_SUM; k++) begin
            feed[k] = words[k];
        end
        din = feed[st_q.idx];

        st_d     = st_q;
        st_d.fin = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.idx  = IW'(START_IDX);
            st_d.crc  = '1;
        end else if (st_q.busy) begin
            st_d.crc = crc_word(st_q.crc, din);
            if (st_q.idx == '0) begin
                st_d.busy = 1'b0;
                st_d.fin  = 1'b1;
            end else begin
                st_d.idx = st_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fin    = st_q.fin;
    assign result = ~st_q.crc;
endmodule

// File: rtl/keystore_irq.sv
module keystore_irq #(
    parameter int NI = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] evt,
    input  logic [NI-1:0] w1c,
    input  logic [NI-1:0] unmask,
    input  logic [NI-1:0] domask,
    output logic [NI-1:0] stat,
    output logic [NI-1:0] mask,
    output logic          irq
);
    typedef struct packed {
        logic [NI-1:0] stat;
        logic [NI-1:0] mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~w1c) | evt;
        st_d.mask = (st_q.mask & ~unmask) | domask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.stat;
    assign mask = st_q.mask;
    assign irq  = |(st_q.stat & ~st_q.mask);
endmodule

// File: rtl/keystore_ctrl.sv
module keystore_ctrl
    import keystore_pkg::*;
#(
    parameter bit WORD8_WO = 1'b1,
    parameter int NUM_IRQ  = 1
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [REG_AW-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    output logic [DATA_W-1:0]  prdata,
    input  logic [NUM_IRQ-1:0] irq_evt,
    output logic               irq
);
    localparam int KIW     = $clog2(NUM_KEY);
    localparam int KEY_HI  = NUM_KEY - 1;
    localparam int NUM_SUM = NUM_KEY - 1;
    localparam logic [REG_AW-1:0] OFS_KEY_LAST = OFS_KEY0 + REG_AW'(4 * KEY_HI);

    logic rst_all_n;
    logic aligned, wr, key_hit, unlock_hit, zap, crc_start, crc_fin, nz_clear;
    logic [REG_AW-1:0] key_off;
    logic [KIW-1:0] key_idx;
    logic [NUM_KEY-1:0] key_we, key_clr;
    logic [NUM_KEY-1:0][DATA_W-1:0] keys;
    logic [DATA_W-1:0] crc_val, rd_mux;
    logic [NUM_IRQ-1:0] istat, imask, i_w1c, i_en, i_dis;
    ctl_st_t st_d, st_q;

    assign rst_all_n = por_n & rst_n;

    // Access decode
    assign aligned    = (paddr[1:0] == 2'b00);
    assign wr         = psel & penable & pwrite & aligned;
    assign key_hit    = aligned && (paddr >= OFS_KEY0) && (paddr <= OFS_KEY_LAST);
    assign key_off    = paddr - OFS_KEY0;
    assign key_idx    = key_off[KIW+1:2];
    assign unlock_hit = wr && (paddr == OFS_UNLK) && (pwdata == UNLOCK_WORD);
    assign zap        = unlock_hit || (wr && (paddr == OFS_CTRL) && pwdata[0]);
    assign crc_start  = wr && (paddr == OFS_CSUM) && st_q.pgm;

    always_comb begin
        for (int i = 0; i < NUM_KEY; i++) begin
            key_we[i]  = wr && key_hit && (key_idx == KIW'(i)) && st_q.pgm &&
                         ((i != KEY_HI) || !st_q.lock);
            key_clr[i] = zap && ((i != KEY_HI) || WORD8_WO);
        end
        nz_clear = (|key_we) && (pwdata != '0) && ((key_idx != KIW'(KEY_HI)) || WORD8_WO);
    end

    assign i_w1c = (wr && paddr == OFS_ISTAT) ? pwdata[NUM_IRQ-1:0] : '0;
    assign i_en  = (wr && paddr == OFS_IEN)   ? pwdata[NUM_IRQ-1:0] : '0;
    assign i_dis = (wr && paddr == OFS_IDIS)  ? pwdata[NUM_IRQ-1:0] : '0;

    keystore_bank #(.NUM_W(NUM_KEY), .DW(DATA_W)) i_bank (
        .clk   (clk),
        .por_n (por_n),
        .we    (key_we),
        .clr   (key_clr),
        .wdata (pwdata),
        .words (keys)
    );

    keystore_crc #(.NUM_SUM(NUM_SUM), .LEAD_ZERO(WORD8_WO)) i_crc (
        .clk    (clk),
        .rst_n  (rst_all_n),
        .start  (crc_start),
        .words  (keys[NUM_SUM-1:0]),
        .fin    (crc_fin),
        .result (crc_val)
    );

    keystore_irq #(.NI(NUM_IRQ)) i_irq (
        .clk    (clk),
        .rst_n  (rst_all_n),
        .evt    (irq_evt),
        .w1c    (i_w1c),
        .unmask (i_en),
        .domask (i_dis),
        .stat   (istat),
        .mask   (imask),
        .irq    (irq)
    );

    // Control state next value
    always_comb begin
        st_d     = st_q;
        st_d.pgm = st_q.pgm | unlock_hit;
        if (zap) begin
            st_d.wiped = 1'b1;
        end else if (nz_clear) begin
            st_d.wiped = 1'b0;
        end
        if (crc_start) begin
            st_d.csum = pwdata;
            st_d.done = 1'b0;
            st_d.pass = 1'b0;
        end else if (crc_fin) begin
            st_d.done = 1'b1;
            st_d.pass = (crc_val == st_q.csum);
        end
        if (wr && paddr == OFS_LOCK && !WORD8_WO) begin
            st_d.lock = st_q.lock | pwdata[0];
        end
        if (wr && paddr == OFS_SERR) begin
            st_d.serr_en = pwdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read path
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            case (paddr)
                OFS_STAT: begin
                    rd_mux[ST_PGM]  = st_q.pgm;
                    rd_mux[ST_WIPE] = st_q.wiped;
                    rd_mux[ST_DONE] = st_q.done;
                    rd_mux[ST_PASS] = st_q.pass;
                end
                OFS_KEY_LAST: rd_mux = WORD8_WO ? '0 : keys[KEY_HI];
                OFS_SERR:     rd_mux[0] = st_q.serr_en;
                OFS_ISTAT:    rd_mux[NUM_IRQ-1:0] = istat;
                OFS_IMASK:    rd_mux[NUM_IRQ-1:0] = imask;
                OFS_LOCK:     rd_mux[0] = st_q.lock;
                default:      rd_mux = '0;
            endcase
        end
        prdata = (psel && !pwrite) ? rd_mux : '0;
    end
endmodule

// File: rtl/keystore_chk.sv
module keystore_chk
    import keystore_pkg::*;
#(
    parameter bit WO = 1'b1
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [REG_AW-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic              pgm,
    input logic              wiped,
    input logic              done,
    input logic              lock,
    input logic              mask0,
    input logic              zap
);
    logic rd_now;
    assign rd_now = psel && !pwrite;

    AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (rd_now && paddr[1:0] != 2'b00) |-> prdata == '0); // R1
    AST_PGM_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        pgm |=> pgm); // R2
    AST_KEY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (rd_now && paddr >= OFS_KEY0 && paddr < 7'h30) |-> prdata == '0); // R3
    AST_CSUM_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (rd_now && paddr == OFS_CSUM) |-> prdata == '0); // R3
    AST_WIPE_FLAG: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        zap |=> wiped); // R4
    AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (rd_now && paddr == OFS_CTRL) |-> prdata == '0); // R4
    AST_DONE_NEEDS_PGM: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        done |-> pgm); // R6
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        lock |=> lock); // R10
    AST_IEN_UNMASKS: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (psel && penable && pwrite && paddr == OFS_IEN && pwdata[0]) |=> !mask0); // R11

    if (WO) begin : g_wo
        AST_WO_NEVER_LOCKS: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
            !lock); // R8
    end
endmodule

bind keystore_ctrl keystore_chk #(.WO(WORD8_WO)) i_chk (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .pgm     (st_q.pgm),
    .wiped   (st_q.wiped),
    .done    (st_q.done),
    .lock    (st_q.lock),
    .mask0   (imask[0]),
    .zap     (zap)
);

// File: tb/test_keystore_ctrl.sv
module test_keystore_ctrl;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [6:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_a;
        logic [31:0] exp_b;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    // exp_a: word 8 write-only build; exp_b: word 8 readable build.
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 7'h00, 32'h0,        32'h0,   32'h0,   4'd12}, // R12 status after reset
        '{1'b0, 7'h3C, 32'h0,        32'h1,   32'h1,   4'd11}, // R11 mask resets to 1
        '{1'b1, 7'h04, 32'h1,        32'h0,   32'h0,   4'd4 },
        '{1'b0, 7'h00, 32'h0,        32'h10,  32'h10,  4'd4 }, // R4 wiped flag
        '{1'b0, 7'h04, 32'h0,        32'h0,   32'h0,   4'd4 }, // R4 self-clear
        '{1'b1, 7'h10, 32'hAAAA,     32'h0,   32'h0,   4'd3 },
        '{1'b0, 7'h00, 32'h0,        32'h10,  32'h10,  4'd3 }, // R3 dropped write
        '{1'b1, 7'h08, 32'h12345678, 32'h0,   32'h0,   4'd2 },
        '{1'b0, 7'h00, 32'h0,        32'h10,  32'h10,  4'd2 }, // R2 wrong value
        '{1'b1, 7'h08, 32'h757BDF0D, 32'h0,   32'h0,   4'd2 },
        '{1'b0, 7'h00, 32'h0,        32'h11,  32'h11,  4'd2 }, // R2 unlocked
        '{1'b0, 7'h08, 32'h0,        32'h0,   32'h0,   4'd2 },
        '{1'b1, 7'h30, 32'h5,        32'h0,   32'h0,   4'd5 },
        '{1'b0, 7'h00, 32'h0,        32'h01,  32'h11,  4'd5 }, // R5 word-8 exception
        '{1'b0, 7'h30, 32'h0,        32'h0,   32'h5,   4'd8 }, // R8 / R9 readback
        '{1'b1, 7'h10, 32'h1,        32'h0,   32'h0,   4'd5 },
        '{1'b0, 7'h00, 32'h0,        32'h01,  32'h01,  4'd5 }, // R5
        '{1'b0, 7'h10, 32'h0,        32'h0,   32'h0,   4'd3 }, // R3 key reads zero
        '{1'b1, 7'h4C, 32'h1,        32'h0,   32'h0,   4'd10},
        '{1'b0, 7'h4C, 32'h0,        32'h0,   32'h1,   4'd10}, // R10 / R8 lock
        '{1'b1, 7'h4C, 32'h0,        32'h0,   32'h0,   4'd10},
        '{1'b0, 7'h4C, 32'h0,        32'h0,   32'h1,   4'd10}, // R10 sticky
        '{1'b1, 7'h30, 32'h77,       32'h0,   32'h0,   4'd9 },
        '{1'b0, 7'h30, 32'h0,        32'h0,   32'h5,   4'd9 }, // R9 locked
        '{1'b1, 7'h34, 32'h1,        32'h0,   32'h0,   4'd13},
        '{1'b0, 7'h34, 32'h0,        32'h1,   32'h1,   4'd13}, // R13
        '{1'b0, 7'h48, 32'h0,        32'h0,   32'h0,   4'd1 }, // R1 undefined
        '{1'b1, 7'h35, 32'h0,        32'h0,   32'h0,   4'd1 },
        '{1'b0, 7'h34, 32'h0,        32'h1,   32'h1,   4'd1 }, // R1 misaligned write
        '{1'b0, 7'h36, 32'h0,        32'h0,   32'h0,   4'd1 }, // R1 misaligned read
        '{1'b0, 7'h0C, 32'h0,        32'h0,   32'h0,   4'd3 }  // R3 checksum reads zero
    };

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [6:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [0:0] irq_evt = '0;
    logic [31:0] prdata_a, prdata_b;
    logic irq_a, irq_b;
    int checks = 0, fails = 0;
    logic [31:0] ra, rb, crc_a, crc_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    keystore_ctrl #(.WORD8_WO(1'b1)) i_keystore_ctrl (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a),
        .irq_evt(irq_evt), .irq(irq_a));

    keystore_ctrl #(.WORD8_WO(1'b0)) i_keystore_ctrl_rd (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b),
        .irq_evt(irq_evt), .irq(irq_b));

    task automatic check(input int req, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d, input logic evt);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1; irq_evt = evt;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; irq_evt = '0;
    endtask

    task automatic bus_rd(input logic [6:0] a, output logic [31:0] va, output logic [31:0] vb);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        va = prdata_a; vb = prdata_b;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Reference CRC-32C, bytewise with reflected bits.
    function automatic logic [31:0] ref_crc(input logic lead, input logic [7:0][31:0] w);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int n = (lead ? 8 : 7); n >= 0; n--) begin
            logic [31:0] word;
            word = (n == 8) ? 32'h0 : w[n];
            for (int by = 0; by < 4; by++) begin
                c = c ^ {24'h0, word[8*by +: 8]};
                for (int k = 0; k < 8; k++) begin
                    c = c[0] ? ((c >> 1) ^ 32'h82F6_3B78) : (c >> 1);
                end
            end
        end
        return ~c;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0][31:0] kw;
        idle(3);
        por_n = 1'b1; rst_n = 1'b1;
        idle(2);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) begin
                bus_wr(VECS[v].addr, VECS[v].data, 1'b0);
            end else begin
                bus_rd(VECS[v].addr, ra, rb);
                check(int'(VECS[v].req), $sformatf("vec %0d wo", v), ra, VECS[v].exp_a);
                check(int'(VECS[v].req), $sformatf("vec %0d rd", v), rb, VECS[v].exp_b);
            end
        end

        // R6 R7: keys now word0=1, others 0 in both builds
        kw = '0; kw[0] = 32'h1;
        crc_a = ref_crc(1'b1, kw);
        crc_b = ref_crc(1'b0, kw);
        bus_wr(7'h0C, crc_a, 1'b0);
        bus_rd(7'h00, ra, rb);
        check(6, "done cleared while busy wo", ra, 32'h001);
        check(6, "done cleared while busy rd", rb, 32'h001);
        idle(14);
        bus_rd(7'h00, ra, rb);
        check(7, "crc with lead zero pass", ra, 32'h301);
        check(7, "crc without lead fail", rb, 32'h101);
        bus_wr(7'h0C, crc_b, 1'b0);
        idle(14);
        bus_rd(7'h00, ra, rb);
        check(7, "second crc wo", ra, 32'h101);
        check(7, "second crc rd", rb, 32'h301);

        // R9: wipe in program mode keeps readable word 8
        bus_wr(7'h04, 32'h1, 1'b0);
        bus_rd(7'h30, ra, rb);
        check(9, "word8 survives wipe", rb, 32'h5);
        bus_rd(7'h00, ra, rb);
        check(4, "wipe in pgm wo", ra, 32'h111);
        check(4, "wipe in pgm rd", rb, 32'h311);
        kw = '0;
        bus_wr(7'h0C, ref_crc(1'b1, kw), 1'b0);
        idle(14);
        bus_rd(7'h00, ra, rb);
        check(7, "all-zero crc wo", ra, 32'h311);
        check(7, "all-zero crc rd", rb, 32'h111);

        // R12: functional reset keeps keys, clears registers
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_rd(7'h00, ra, rb);
        check(12, "status after rst wo", ra, 32'h0);
        check(12, "status after rst rd", rb, 32'h0);
        bus_rd(7'h30, ra, rb);
        check(12, "word8 kept over rst", rb, 32'h5);
        bus_rd(7'h4C, ra, rb);
        check(12, "lock cleared by rst", rb, 32'h0);
        bus_rd(7'h34, ra, rb);
        check(13, "serr cleared by rst", ra, 32'h0);

        // R6: checksum write outside program mode
        bus_wr(7'h0C, 32'h0, 1'b0);
        idle(14);
        bus_rd(7'h00, ra, rb);
        check(6, "csum ignored outside pgm", ra, 32'h0);
        check(6, "csum ignored outside pgm rd", rb, 32'h0);

        // R11: interrupts
        @(negedge clk); irq_evt = 1'b1;
        @(negedge clk); irq_evt = 1'b0;
        bus_rd(7'h38, ra, rb);
        check(11, "istat set by event", ra, 32'h1);
        check(11, "irq masked", {31'h0, irq_a}, 32'h0);
        bus_wr(7'h40, 32'h1, 1'b0);
        check(11, "irq after enable", {31'h0, irq_a}, 32'h1);
        bus_rd(7'h3C, ra, rb);
        check(11, "mask cleared by enable", ra, 32'h0);
        bus_rd(7'h40, ra, rb);
        check(11, "enable reads zero", ra, 32'h0);
        bus_wr(7'h3C, 32'h1, 1'b0);
        bus_rd(7'h3C, ra, rb);
        check(11, "mask ignores direct write", ra, 32'h0);
        bus_wr(7'h44, 32'h1, 1'b0);
        check(11, "irq after disable", {31'h0, irq_b}, 32'h0);
        bus_rd(7'h3C, ra, rb);
        check(11, "mask set by disable", rb, 32'h1);
        bus_rd(7'h44, ra, rb);
        check(11, "disable reads zero", rb, 32'h0);
        bus_wr(7'h40, 32'h1, 1'b0);
        bus_wr(7'h38, 32'h1, 1'b1);
        bus_rd(7'h38, ra, rb);
        check(11, "event wins over clear", ra, 32'h1);
        bus_wr(7'h38, 32'h1, 1'b0);
        bus_rd(7'h38, ra, rb);
        check(11, "istat cleared by w1c", ra, 32'h0);
        check(11, "irq low after clear", {31'h0, irq_a}, 32'h0);

        // R12: power-on reset clears keys
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        bus_rd(7'h30, ra, rb);
        check(12, "word8 cleared by por", rb, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule